// File: doc/BRIEF.md
# Codec Configuration Word Router

This block sits behind the serial shifter of a voiceband codec. It takes complete 16-bit words handed over by the shifter, each tagged with the data/control qualifier captured at frame start. It sorts every word into one of four kinds: a DAC sample, a configuration write, a readback request or a readback ready. Samples go to a holding register. That register is presented to the DAC path once per frame tick, and it is repeated when the host sent nothing new. Configuration writes update a register whose fields drive the preamp, the input multiplexer, both high-pass bypasses, the two power enables and the 3-bit output gain code. The gain code is also shown as a signed gain in dB.

Readback is a two-step handshake. A request word arms it and raises a pending flag, which tells the serial port to finish its current transfer and hold further sample output. A later ready word captures the register contents into an outgoing readback word. The serial port takes that word over a valid/ready pair. The inbound word stream is valid/ready as well. `in_ready` stays high except while a captured readback word waits for acceptance, so the upstream shifter must hold its word during that stall. The readback word stays stable until `rb_ready` is seen. After the handshake completes, the pending flag drops and sample traffic resumes.

Top module: `cfg_word_router`

## Requirements
- R1: After reset every configuration field is 0 (powered down, preamp bypassed, NORM input, both filters inserted, gain code 0 so `gain_db` = +6), `rb_valid` and `rb_pending` are low, `pwr_start` is low and `in_ready` is high.
- R2: An accepted word with `in_is_data` = 1 is loaded into `dac_hold_word` on that edge, whatever its bit 15, and leaves every configuration output unchanged.
- R3: A one-cycle `frame_tick` gives a one-cycle `dac_frame_valid` on the next cycle, with `dac_frame_word` equal to the latest held sample. `dac_frame_fresh` is 1 only if a sample was accepted since the previous tick; otherwise the previous sample is repeated with `dac_frame_fresh` = 0.
- R4: An accepted word with `in_is_data` = 0 and bit 15 = 0 is a configuration write, visible on the outputs the cycle after acceptance. Field positions: bit 0 `pre_on` (1 = +20 dB inserted), bit 1 `mux_aux` (1 = AUX, 0 = NORM), bit 2 `dac_hp_byp`, bit 3 `adc_hp_byp` (1 = bypass), bit 4 `pwr_ana`, bit 5 `pwr_dig` (1 = operating), bits 9..7 `gain_code`.
- R5: Reserved bits 6 and 10..15 are not stored; they always read back as 0.
- R6: `gain_db` equals 6 − 3 × `gain_code`, signed: code 0 gives +6 and code 7 gives −15.
- R7: A control word with bit 15 = 1 and bit 0 = 0 is a read request. It leaves the register unchanged and raises `rb_pending` the next cycle.
- R8: A control word with bit 15 = 1 and bit 0 = 1 that arrives while a request is pending raises `rb_valid` the next cycle. `rb_word` then holds the register (fields at their R4 positions, reserved bits 0). `in_ready` is low while `rb_valid` is high. Acceptance by `rb_ready` clears `rb_valid` and `rb_pending` on the following cycle.
- R9: A read ready word with no pending request is ignored: no readback word, no pending flag, and the register is unchanged.
- R10: A data word accepted while a readback is pending is loaded into `dac_hold_word`, and the request stays pending.
- R11: `pwr_start` pulses for one cycle, aligned with the updated fields, when a configuration write sets both power bits while at least one of them was clear before. A write that keeps both set gives no pulse.
- R12: While `rb_valid` is high and `rb_ready` is low, `rb_valid` stays high and `rb_word` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inbound word valid |
| in_ready | output | 1 | Inbound word accepted when high with in_valid |
| in_is_data | input | 1 | Qualifier: 1 = DAC sample, 0 = control |
| in_word | input | 16 | Inbound word |
| frame_tick | input | 1 | One pulse per sample frame |
| dac_hold_word | output | 16 | DAC sample holding register |
| dac_frame_valid | output | 1 | Per-frame sample strobe |
| dac_frame_word | output | 16 | Sample issued this frame |
| dac_frame_fresh | output | 1 | Issued sample is new since last frame |
| pre_on | output | 1 | Input preamp inserted |
| mux_aux | output | 1 | Input mux on AUX |
| dac_hp_byp | output | 1 | DAC high-pass bypassed |
| adc_hp_byp | output | 1 | ADC high-pass bypassed |
| pwr_ana | output | 1 | Analog section operating |
| pwr_dig | output | 1 | Digital section operating |
| gain_code | output | 3 | Output gain code |
| gain_db | output | 6 | Output gain in dB, signed |
| pwr_start | output | 1 | Power-up start pulse for the serial port |
| rb_pending | output | 1 | Readback in progress; hold sample output |
| rb_valid | output | 1 | Readback word valid |
| rb_ready | input | 1 | Serial port takes the readback word |
| rb_word | output | 16 | Readback word |

## Verification
All 1024 values of the ten defined low bits are written as configuration words, each with a varying pattern in the reserved high bits. Every write is followed by a full request/ready readback, so field placement, reserved-bit masking, the gain arithmetic and power-up edge detection are all separated across the whole code space. A run of sample words with frame ticks in between separates fresh issue from repeated issue. Stray ready words, data words arriving mid-handshake and held-back `rb_ready` separate the handshake states from one another.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
  localparam int WORD_W  = 16;
  localparam int GAIN_W  = 3;
  localparam int B_PRE   = 0;
  localparam int B_MUX   = 1;
  localparam int B_DHP   = 2;
  localparam int B_AHP   = 3;
  localparam int B_PWA   = 4;
  localparam int B_PWD   = 5;
  localparam int B_RSV   = 6;
  localparam int B_GAIN  = 7;
  localparam int B_TOPFD = B_GAIN + GAIN_W;

  typedef enum logic [1:0] {
    K_DATA  = 2'd0,
    K_WRITE = 2'd1,
    K_REQ   = 2'd2,
    K_RDY   = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    RB_IDLE = 2'd0,
    RB_WAIT = 2'd1,
    RB_SEND = 2'd2
  } rb_state_e;

  typedef struct packed {
    logic [GAIN_W-1:0] gain;
    logic              pwr_dig;
    logic              pwr_ana;
    logic              adc_hp_byp;
    logic              dac_hp_byp;
    logic              mux_aux;
    logic              pre_on;
  } cfg_t;
endpackage

// File: rtl/cfgw_classify.sv
module cfgw_classify
  import cfgw_pkg::*;
(
  input  logic  is_data,
  input  logic  msb,
  input  logic  lsb,
  output kind_e kind
);
  always_comb begin
    if (is_data)      kind = K_DATA;
    else if (!msb)    kind = K_WRITE;
    else if (!lsb)    kind = K_REQ;
    else              kind = K_RDY;
  end
endmodule

// File: rtl/cfgw_cfg_reg.sv
module cfgw_cfg_reg
  import cfgw_pkg::*;
#(
  parameter int DB_W         = 6,
  parameter int GAIN_TOP_DB  = 6,
  parameter int GAIN_STEP_DB = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  cfg_t                   wr_cfg,
  output cfg_t                   cfg,
  output logic                   pwr_start,
  output logic signed [DB_W-1:0] gain_db
);
  localparam logic signed [DB_W-1:0] TOP_S  = DB_W'(GAIN_TOP_DB);
  localparam logic signed [DB_W-1:0] STEP_S = DB_W'(GAIN_STEP_DB);

  logic both_now, both_new;
  logic [DB_W-1:0] code_ext;

  assign both_now = cfg.pwr_ana & cfg.pwr_dig;
  assign both_new = wr_cfg.pwr_ana & wr_cfg.pwr_dig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg       <= '0;
      pwr_start <= 1'b0;
    end else begin
      pwr_start <= wr_en & both_new & ~both_now;
      if (wr_en) cfg <= wr_cfg;
    end
  end

  assign code_ext = {{(DB_W-GAIN_W){1'b0}}, cfg.gain};
  assign gain_db  = TOP_S - STEP_S * $signed(code_ext);
endmodule

// File: rtl/cfgw_dac_hold.sv
module cfgw_dac_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         tick,
  output logic [W-1:0] hold,
  output logic         frame_valid,
  output logic [W-1:0] frame_word,
  output logic         frame_fresh
);
  logic fresh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold        <= '0;
      fresh_q     <= 1'b0;
      frame_valid <= 1'b0;
      frame_word  <= '0;
      frame_fresh <= 1'b0;
    end else begin
      if (load) hold <= din;
      fresh_q     <= tick ? 1'b0 : (fresh_q | load);
      frame_valid <= tick;
      if (tick) begin
        frame_word  <= load ? din : hold;
        frame_fresh <= fresh_q | load;
      end
    end
  end
endmodule

// File: rtl/cfgw_readback.sv
module cfgw_readback
  import cfgw_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_in,
  input  logic         rdy_in,
  input  logic [W-1:0] reg_word,
  input  logic         rb_ready,
  output logic         rb_valid,
  output logic [W-1:0] rb_word,
  output logic         pending,
  output logic         stall
);
  rb_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RB_IDLE;
      rb_word <= '0;
    end else begin
      unique case (state)
        RB_IDLE: if (req_in) state <= RB_WAIT;
        RB_WAIT: if (rdy_in) begin
          state   <= RB_SEND;
          rb_word <= reg_word;
        end
        RB_SEND: if (rb_ready) state <= RB_IDLE;
        default: state <= RB_IDLE;
      endcase
    end
  end

  assign rb_valid = (state == RB_SEND);
  assign stall    = (state == RB_SEND);
  assign pending  = (state != RB_IDLE);
endmodule

// File: rtl/cfg_word_router.sv
module cfg_word_router
  import cfgw_pkg::*;
#(
  parameter int W            = WORD_W,
  parameter int DB_W         = 6,
  parameter int GAIN_TOP_DB  = 6,
  parameter int GAIN_STEP_DB = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   in_is_data,
  input  logic [W-1:0]           in_word,
  input  logic                   frame_tick,
  output logic [W-1:0]           dac_hold_word,
  output logic                   dac_frame_valid,
  output logic [W-1:0]           dac_frame_word,
  output logic                   dac_frame_fresh,
  output logic                   pre_on,
  output logic                   mux_aux,
  output logic                   dac_hp_byp,
  output logic                   adc_hp_byp,
  output logic                   pwr_ana,
  output logic                   pwr_dig,
  output logic [GAIN_W-1:0]      gain_code,
  output logic signed [DB_W-1:0] gain_db,
  output logic                   pwr_start,
  output logic                   rb_pending,
  output logic                   rb_valid,
  input  logic                   rb_ready,
  output logic [W-1:0]           rb_word
);
  localparam int RSV_HI_W = W - B_TOPFD;

  kind_e    kind;
  logic     accept, stall;
  cfg_t     wr_cfg, cfg;
  logic [W-1:0] reg_word;

  cfgw_classify u_cls (
    .is_data (in_is_data),
    .msb     (in_word[W-1]),
    .lsb     (in_word[B_PRE]),
    .kind    (kind)
  );

  assign in_ready = ~stall;
  assign accept   = in_valid & in_ready;

  always_comb begin
    wr_cfg.pre_on     = in_word[B_PRE];
    wr_cfg.mux_aux    = in_word[B_MUX];
    wr_cfg.dac_hp_byp = in_word[B_DHP];
    wr_cfg.adc_hp_byp = in_word[B_AHP];
    wr_cfg.pwr_ana    = in_word[B_PWA];
    wr_cfg.pwr_dig    = in_word[B_PWD];
    wr_cfg.gain       = in_word[B_GAIN +: GAIN_W];
  end

  cfgw_cfg_reg #(
    .DB_W(DB_W), .GAIN_TOP_DB(GAIN_TOP_DB), .GAIN_STEP_DB(GAIN_STEP_DB)
  ) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (accept && kind == K_WRITE),
    .wr_cfg    (wr_cfg),
    .cfg       (cfg),
    .pwr_start (pwr_start),
    .gain_db   (gain_db)
  );

  cfgw_dac_hold #(.W(W)) u_dac (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (accept && kind == K_DATA),
    .din         (in_word),
    .tick        (frame_tick),
    .hold        (dac_hold_word),
    .frame_valid (dac_frame_valid),
    .frame_word  (dac_frame_word),
    .frame_fresh (dac_frame_fresh)
  );

  assign reg_word = {{RSV_HI_W{1'b0}}, cfg.gain, 1'b0, cfg.pwr_dig, cfg.pwr_ana,
                     cfg.adc_hp_byp, cfg.dac_hp_byp, cfg.mux_aux, cfg.pre_on};

  cfgw_readback #(.W(W)) u_rb (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_in   (accept && kind == K_REQ),
    .rdy_in   (accept && kind == K_RDY),
    .reg_word (reg_word),
    .rb_ready (rb_ready),
    .rb_valid (rb_valid),
    .rb_word  (rb_word),
    .pending  (rb_pending),
    .stall    (stall)
  );

  assign pre_on     = cfg.pre_on;
  assign mux_aux    = cfg.mux_aux;
  assign dac_hp_byp = cfg.dac_hp_byp;
  assign adc_hp_byp = cfg.adc_hp_byp;
  assign pwr_ana    = cfg.pwr_ana;
  assign pwr_dig    = cfg.pwr_dig;
  assign gain_code  = cfg.gain;
endmodule

// File: rtl/cfgw_checker.sv
module cfgw_checker
  import cfgw_pkg::*;
#(
  parameter int W            = WORD_W,
  parameter int DB_W         = 6,
  parameter int GAIN_TOP_DB  = 6,
  parameter int GAIN_STEP_DB = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   in_is_data,
  input logic [W-1:0]           in_word,
  input logic                   pre_on,
  input logic                   mux_aux,
  input logic                   dac_hp_byp,
  input logic                   adc_hp_byp,
  input logic                   pwr_ana,
  input logic                   pwr_dig,
  input logic [GAIN_W-1:0]      gain_code,
  input logic signed [DB_W-1:0] gain_db,
  input logic                   pwr_start,
  input logic                   rb_valid,
  input logic                   rb_ready,
  input logic [W-1:0]           rb_word
);
  localparam int LOW_DB = GAIN_TOP_DB - GAIN_STEP_DB * ((1 << GAIN_W) - 1);

  logic [GAIN_W+5:0] cfg_bus;
  assign cfg_bus = {gain_code, pwr_dig, pwr_ana, adc_hp_byp, dac_hp_byp, mux_aux, pre_on};

  assert_data_keeps_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_is_data) |=> $stable(cfg_bus));

  assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid |-> (rb_word[W-1:B_TOPFD] == '0 && rb_word[B_RSV] == 1'b0));

  assert_gain_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(gain_db) <= GAIN_TOP_DB) && (int'(gain_db) >= LOW_DB));

  assert_read_word_keeps_cfg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_is_data && in_word[W-1]) |=> $stable(cfg_bus));

  assert_stall_while_send_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid |-> !in_ready);

  assert_pwr_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_start |-> (pwr_ana && pwr_dig));

  assert_pwr_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_start |=> !pwr_start);

  assert_rb_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_valid && !rb_ready) |=> (rb_valid && $stable(rb_word)));
endmodule

bind cfg_word_router cfgw_checker #(
  .W(W), .DB_W(DB_W), .GAIN_TOP_DB(GAIN_TOP_DB), .GAIN_STEP_DB(GAIN_STEP_DB)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_is_data (in_is_data),
  .in_word    (in_word),
  .pre_on     (pre_on),
  .mux_aux    (mux_aux),
  .dac_hp_byp (dac_hp_byp),
  .adc_hp_byp (adc_hp_byp),
  .pwr_ana    (pwr_ana),
  .pwr_dig    (pwr_dig),
  .gain_code  (gain_code),
  .gain_db    (gain_db),
  .pwr_start  (pwr_start),
  .rb_valid   (rb_valid),
  .rb_ready   (rb_ready),
  .rb_word    (rb_word)
);

// File: tb/tb_cfg_word_router.sv
module tb_cfg_word_router;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_is_data = 1'b0, frame_tick = 1'b0, rb_ready = 1'b0;
  logic [15:0] in_word = '0;
  logic in_ready, dac_frame_valid, dac_frame_fresh;
  logic [15:0] dac_hold_word, dac_frame_word, rb_word;
  logic pre_on, mux_aux, dac_hp_byp, adc_hp_byp, pwr_ana, pwr_dig, pwr_start;
  logic rb_pending, rb_valid;
  logic [2:0] gain_code;
  logic signed [5:0] gain_db;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_word_router dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_is_data(in_is_data), .in_word(in_word), .frame_tick(frame_tick),
    .dac_hold_word(dac_hold_word), .dac_frame_valid(dac_frame_valid),
    .dac_frame_word(dac_frame_word), .dac_frame_fresh(dac_frame_fresh),
    .pre_on(pre_on), .mux_aux(mux_aux), .dac_hp_byp(dac_hp_byp),
    .adc_hp_byp(adc_hp_byp), .pwr_ana(pwr_ana), .pwr_dig(pwr_dig),
    .gain_code(gain_code), .gain_db(gain_db), .pwr_start(pwr_start),
    .rb_pending(rb_pending), .rb_valid(rb_valid), .rb_ready(rb_ready),
    .rb_word(rb_word)
  );

  function automatic int fields();
    return {23'd0, gain_code, pwr_dig, pwr_ana, adc_hp_byp, dac_hp_byp, mux_aux, pre_on};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic q, input logic [15:0] w);
    @(negedge clk);
    in_valid = 1'b1; in_is_data = q; in_word = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); frame_tick = 1'b1;
    @(negedge clk); frame_tick = 1'b0;
  endtask

  task automatic release_rb();
    rb_ready = 1'b1;
    @(negedge clk);
    rb_ready = 1'b0;
    chk("R8 rb_valid drop", int'(rb_valid), 0);
    chk("R8 pending drop", int'(rb_pending), 0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int prev_both = 0;
    int held = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 fields", fields(), 0);
    chk("R1 gain_db", int'(gain_db), 6);
    chk("R1 rb_valid", int'(rb_valid), 0);
    chk("R1 pending", int'(rb_pending), 0);
    chk("R1 pwr_start", int'(pwr_start), 0);
    chk("R1 in_ready", int'(in_ready), 1);

    // R9 stray ready word ignored
    put(1'b0, 16'h8001);
    chk("R9 no rb_valid", int'(rb_valid), 0);
    chk("R9 no pending", int'(rb_pending), 0);
    chk("R9 fields", fields(), 0);

    // R2/R3 samples and frame repetition
    for (int i = 0; i < 8; i++) begin
      logic [15:0] s;
      s = 16'(i * 16'h2357 + 16'h8001);
      put(1'b1, s);
      chk("R2 hold", int'(dac_hold_word), int'(s));
      chk("R2 cfg untouched", fields(), 0);
      tick();
      chk("R3 frame valid", int'(dac_frame_valid), 1);
      chk("R3 frame word", int'(dac_frame_word), int'(s));
      chk("R3 fresh", int'(dac_frame_fresh), 1);
      @(negedge clk);
      chk("R3 strobe one cycle", int'(dac_frame_valid), 0);
      tick();
      chk("R3 repeat word", int'(dac_frame_word), int'(s));
      chk("R3 repeat not fresh", int'(dac_frame_fresh), 0);
      held = int'(s);
    end

    // R10 data during pending readback
    put(1'b0, 16'h8000);
    chk("R7 pending", int'(rb_pending), 1);
    put(1'b1, 16'h5AA5);
    chk("R10 hold", int'(dac_hold_word), 16'h5AA5);
    chk("R10 still pending", int'(rb_pending), 1);
    chk("R10 no rb_valid", int'(rb_valid), 0);
    put(1'b0, 16'h8001);
    chk("R8 rb_valid", int'(rb_valid), 1);
    release_rb();

    // R4/R5/R6/R7/R8/R11/R12 exhaustive sweep of defined bits
    for (int v = 0; v < 1024; v++) begin
      logic [15:0] w;
      int junk, both, exp_rb;
      junk   = (v * 7 + 3) % 32;
      w      = {1'b0, 5'(junk), 10'(v)};
      both   = ((v >> 4) & 3) == 3 ? 1 : 0;
      exp_rb = v & 16'h03BF;
      put(1'b0, w);
      chk("R4 fields", fields(), ((v >> 7) << 6) | (v & 63));
      chk("R6 gain_db", int'(gain_db), 6 - 3 * (v >> 7));
      chk("R11 pwr_start", int'(pwr_start), (both == 1 && prev_both == 0) ? 1 : 0);
      prev_both = both;
      put(1'b0, 16'h8000 | 16'((v * 5) & 16'h7FFE));
      chk("R7 pending", int'(rb_pending), 1);
      chk("R7 unchanged", fields(), ((v >> 7) << 6) | (v & 63));
      put(1'b0, 16'h8001);
      chk("R8 rb_valid", int'(rb_valid), 1);
      chk("R8 in_ready low", int'(in_ready), 0);
      chk("R5 rb_word", int'(rb_word), exp_rb);
      if ((v % 64) == 5) begin
        repeat (3) @(negedge clk);
        chk("R12 held valid", int'(rb_valid), 1);
        chk("R12 held word", int'(rb_word), exp_rb);
      end
      release_rb();
    end
    chk("R2 hold kept across writes", int'(dac_hold_word), 16'h5AA5);
    if (held == 0) n_bad++;

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule